// File: doc/BRIEF.md
# NAND Sector Hamming ECC Generator

This block computes the error-correction code of one 512-byte NAND sector while the sector's bytes stream past on an 8-bit path. The sector is treated as two independent 256-byte halves. Each half gets a 16-bit line parity and a 6-bit column parity, which together let a host correct one flipped bit per half, so two per sector. A software-visible mode code drives the block through three phases: clearing, accumulating and reading out.

To use it, write the clear code, make one dummy read, write the accumulate code and stream 512 bytes with the valid strobe. Then write the readout code and collect the six code bytes as three 16-bit words. Each word is on the read port before its read strobe, and the strobe steps to the next word.

Top module: `nand_ecc_gen`

## Requirements
- R1: After `rst_n` is low, the block is idle: `rd_data_o` is 0, the accumulators are zero, and it is not armed.
- R2: A cycle with `mode_we_i` high loads a mode from `mode_i`. 0xF4 selects clear, 0xB4 selects accumulate and 0xD4 selects readout. Any other code is ignored and the current mode stays.
- R3: While in clear mode, every cycle zeroes both halves' parities, the byte count and the read pointer. A read strobe during clear mode arms the block. Writing the clear code disarms it.
- R4: While the block is not armed, bytes offered in accumulate mode are ignored.
- R5: Line parity of a half has 16 bits. For each byte at address a (0..255 within its half) with odd bit-parity p, bit 2k+1 toggles by p when a[k]=1 and bit 2k toggles by p when a[k]=0, for k = 0..7.
- R6: Column parity bit 2c+1 is the XOR over the half of all data bits whose bit index j has j[c]=1. Bit 2c uses j[c]=0, for c = 0..2. The column byte is {cp[5:0], 2'b11}.
- R7: Bytes 0..255 of the sector feed the first half and bytes 256..511 feed the second. Bytes offered after the 512th are ignored.
- R8: A byte is taken only in a cycle with `byte_vld_i` high in accumulate mode.
- R9: In readout mode the words are presented in this order: {lp0[15:8], lp0[7:0]}, then {lp1[7:0], col0}, then {col1, lp1[15:8]}. Outside readout mode `rd_data_o` is 0.
- R10: In readout mode each read strobe advances to the next word, and the pointer wraps from the third word back to the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we_i | input | 1 | Mode code write strobe |
| mode_i | input | 8 | Mode code |
| byte_vld_i | input | 1 | Data byte valid |
| byte_i | input | 8 | Data byte |
| rd_i | input | 1 | Read strobe |
| rd_data_o | output | 16 | Result word |

## Verification
On every cycle the assertions check the following: the byte count stays within one sector, and the read pointer stays within three words. Clear mode must leave the parities and pointer at zero, and an unarmed block must not move its accumulators. The pointer must step by one on each read. The column word must carry its two fixed low bits. Whether the parity values are correct for real data can only be shown by the bench, which streams sectors against a bit-level model. The bench also covers the ordering of the packed words, the arming handshake, bytes past the sector end, and ignored mode codes.

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen #(
  parameter logic [7:0] CODE_RST = 8'hF4,
  parameter logic [7:0] CODE_ACC = 8'hB4,
  parameter logic [7:0] CODE_RES = 8'hD4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we_i,
  input  logic [7:0]  mode_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic        rd_i,
  output logic [15:0] rd_data_o
);
  localparam int AW     = 8;
  localparam int LPW    = 2 * AW;
  localparam int CPW    = 6;
  localparam int CW     = AW + 2;
  localparam int SECTOR = 2 * (2 ** AW);

  typedef enum logic [1:0] {M_IDLE = 2'd0, M_RST = 2'd1, M_ACC = 2'd2, M_RES = 2'd3} mode_e;

  mode_e          mode_q;
  logic           armed_q;
  logic [CW-1:0]  cnt_q;
  logic [1:0]     ptr_q;
  logic [LPW-1:0] lp_q [2];
  logic [CPW-1:0] cp_q [2];

  logic           par;
  logic [AW-1:0]  addr;
  logic           half;
  logic           take;
  logic [LPW-1:0] lp_hit;
  logic [CPW-1:0] cp_hit;
  logic [7:0]     col0, col1;
  logic [15:0]    word;

  assign par  = ^byte_i;
  assign addr = cnt_q[AW-1:0];
  assign half = cnt_q[AW];
  assign take = (mode_q == M_ACC) && byte_vld_i && armed_q && (cnt_q < CW'(SECTOR));

  always_comb begin
    for (int k = 0; k < AW; k++) begin
      lp_hit[2*k+1] = par & addr[k];
      lp_hit[2*k]   = par & ~addr[k];
    end
  end

  assign cp_hit = {^(byte_i & 8'hF0), ^(byte_i & 8'h0F),
                   ^(byte_i & 8'hCC), ^(byte_i & 8'h33),
                   ^(byte_i & 8'hAA), ^(byte_i & 8'h55)};

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rst_n || mode_q == M_RST) begin
        lp_q[h] <= '0;
        cp_q[h] <= '0;
      end else if (take && half == 1'(h)) begin
        lp_q[h] <= lp_q[h] ^ lp_hit;
        cp_q[h] <= cp_q[h] ^ cp_hit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= M_IDLE;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      ptr_q   <= '0;
    end else begin
      case (mode_q)
        M_RST: begin
          cnt_q <= '0;
          ptr_q <= '0;
          if (rd_i) armed_q <= 1'b1;
        end
        M_ACC: if (take) cnt_q <= cnt_q + 1'b1;
        M_RES: if (rd_i) ptr_q <= (ptr_q == 2'd2) ? 2'd0 : ptr_q + 2'd1;
        default: ;
      endcase
      if (mode_we_i) begin
        if (mode_i == CODE_RST) begin
          mode_q  <= M_RST;
          armed_q <= 1'b0;
        end else if (mode_i == CODE_ACC) begin
          mode_q <= M_ACC;
        end else if (mode_i == CODE_RES) begin
          mode_q <= M_RES;
        end
      end
    end
  end

  assign col0 = {cp_q[0], 2'b11};
  assign col1 = {cp_q[1], 2'b11};

  always_comb begin
    case (ptr_q)
      2'd1:    word = {lp_q[1][7:0], col0};
      2'd2:    word = {col1, lp_q[1][15:8]};
      default: word = lp_q[0];
    endcase
  end

  assign rd_data_o = (mode_q == M_RES) ? word : 16'h0000;
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode,
  input logic        armed,
  input logic [9:0]  cnt,
  input logic [1:0]  ptr,
  input logic [15:0] lp0,
  input logic [15:0] lp1,
  input logic        rd_i,
  input logic [15:0] rd_data_o
);
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n) cnt <= 10'd512);

  assert_ptr_range_R10: assert property (@(posedge clk) disable iff (!rst_n) ptr != 2'd3);

  assert_rst_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |=> (lp0 == 16'h0 && lp1 == 16'h0 && ptr == 2'd0 && cnt == 10'd0));

  assert_unarmed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && mode != 2'd1) |=> ($stable(lp0) && $stable(lp1) && $stable(cnt)));

  assert_ptr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && rd_i && ptr < 2'd2) |=> (ptr == $past(ptr) + 2'd1));

  assert_col_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && ptr == 2'd1) |-> (rd_data_o[1:0] == 2'b11));
endmodule

bind nand_ecc_gen nand_ecc_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_q), .armed(armed_q), .cnt(cnt_q),
  .ptr(ptr_q), .lp0(lp_q[0]), .lp1(lp_q[1]), .rd_i(rd_i), .rd_data_o(rd_data_o)
);

// File: tb/sim_nand_ecc_gen.sv
`timescale 1ns/1ps
module sim_nand_ecc_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_we = 1'b0, bvld = 1'b0, rd = 1'b0;
  logic [7:0] mode = 8'h00, bdat = 8'h00;
  logic [15:0] rdata;

  int n_cmp = 0, n_bad = 0;
  logic [7:0]  mem [512];
  logic [15:0] exp_w [3];

  always #2.5 clk = ~clk;

  nand_ecc_gen u0 (.clk(clk), .rst_n(rst_n), .mode_we_i(mode_we), .mode_i(mode),
    .byte_vld_i(bvld), .byte_i(bdat), .rd_i(rd), .rd_data_o(rdata));

  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{16'h0000, 16'h0100, 16'h0205, 16'h0337, 16'h0409, 16'h055A};

  function automatic logic [7:0] gen(int kind, int seed, int i);
    case (kind)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'(i + seed);
      3: return 8'((i * seed) ^ (i >> 3) ^ seed);
      4: return (i == seed * 37 + 3) ? 8'h10 : 8'h00;
      default: return 8'(i >> 1) ^ 8'(seed);
    endcase
  endfunction

  task automatic model();
    logic [15:0] lp [2];
    logic [5:0]  cp [2];
    for (int h = 0; h < 2; h++) begin
      lp[h] = '0; cp[h] = '0;
      for (int a = 0; a < 256; a++) begin
        logic [7:0] b;
        logic p;
        b = mem[h*256 + a];
        p = 1'b0;
        for (int j = 0; j < 8; j++) begin
          p = p ^ b[j];
          for (int c = 0; c < 3; c++)
            if (j[c]) cp[h][2*c+1] = cp[h][2*c+1] ^ b[j];
            else      cp[h][2*c]   = cp[h][2*c]   ^ b[j];
        end
        for (int k = 0; k < 8; k++)
          if (a[k]) lp[h][2*k+1] = lp[h][2*k+1] ^ p;
          else      lp[h][2*k]   = lp[h][2*k]   ^ p;
      end
    end
    exp_w[0] = lp[0];
    exp_w[1] = {lp[1][7:0], cp[0], 2'b11};
    exp_w[2] = {cp[1], 2'b11, lp[1][15:8]};
  endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic set_mode(logic [7:0] code);
    @(negedge clk); mode = code; mode_we = 1'b1;
    @(posedge clk); #1 mode_we = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd = 1'b1;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
  endtask

  task automatic stream(int kind, int seed, int n, logic vld, logic record);
    for (int i = 0; i < n; i++) begin
      if (i % 7 == 3) begin
        @(negedge clk); bvld = 1'b0; bdat = 8'hA5;
        @(posedge clk); #1;
      end
      @(negedge clk); bvld = vld; bdat = gen(kind, seed, i);
      if (record && i < 512) mem[i] = bdat;
      @(posedge clk); #1 bvld = 1'b0;
    end
  endtask

  task automatic read_all(string tag);
    @(negedge clk);
    for (int w = 0; w < 3; w++) begin
      #1 check(tag, rdata, exp_w[w]);
      pulse_rd();
    end
  endtask

  task automatic arm_and_acc();
    set_mode(8'hF4);
    pulse_rd();
    set_mode(8'hB4);
  endtask

  initial begin
    #(5.0 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset output", rdata, 16'h0000);
    set_mode(8'hD4);
    clear_mem(); model();
    read_all("R1 reset accumulators zero");

    // Table walk: R5 R6 R7 R8 R9 with varied data patterns
    for (int v = 0; v < NV; v++) begin
      arm_and_acc();
      stream(int'(VEC[v][15:8]), int'(VEC[v][7:0]), 512, 1'b1, 1'b1);
      model();
      set_mode(8'hD4);
      read_all("R5 R6 R9 vector");
    end

    // R10: wrap back to first word after three reads
    @(negedge clk); #1 check("R10 wrap to first word", rdata, exp_w[0]);

    // R2: unknown code ignored, still in readout
    set_mode(8'h00);
    @(negedge clk); #1 check("R2 unknown code ignored", rdata, exp_w[0]);
    // R9: accumulate mode shows zero
    set_mode(8'hB4);
    @(negedge clk); #1 check("R9 zero outside readout", rdata, 16'h0000);

    // R3: clear mode wipes results
    set_mode(8'hF4);
    set_mode(8'hD4);
    clear_mem(); model();
    read_all("R3 clear wipes parity");

    // R4: accumulate without dummy read ignored
    set_mode(8'hF4);
    set_mode(8'hB4);
    stream(3, 11, 40, 1'b1, 1'b0);
    set_mode(8'hD4);
    clear_mem(); model();
    read_all("R4 unarmed bytes ignored");

    // R3: rewriting clear code disarms
    set_mode(8'hF4);
    pulse_rd();
    set_mode(8'hF4);
    set_mode(8'hB4);
    stream(2, 9, 20, 1'b1, 1'b0);
    set_mode(8'hD4);
    read_all("R3 clear write disarms");

    // R8: bytes without valid strobe ignored
    arm_and_acc();
    stream(1, 0, 30, 1'b0, 1'b0);
    set_mode(8'hD4);
    read_all("R8 no valid no effect");

    // R7: bytes past the 512th ignored
    arm_and_acc();
    clear_mem();
    stream(3, 77, 520, 1'b1, 1'b1);
    model();
    set_mode(8'hD4);
    read_all("R7 sector end");

    // R7: byte 256 lands in second half only
    arm_and_acc();
    clear_mem();
    for (int i = 0; i < 257; i++) begin
      @(negedge clk); bvld = 1'b1; bdat = (i == 256) ? 8'h01 : 8'h00;
      mem[i] = bdat;
      @(posedge clk); #1 bvld = 1'b0;
    end
    model();
    set_mode(8'hD4);
    read_all("R7 half split");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule